// File: doc/BRIEF.md
# Carry Boolean Bit Processor

This block runs single-bit Boolean instructions for an 8-bit controller core. Each instruction combines the carry flag with one bit of a 4 KB bit-addressable data region, or it changes a single memory bit. The caller presents an opcode byte and two operand bytes, pulses `start`, and the block carries out the work on a simple synchronous memory port. That port has one cycle of read latency. When the instruction finishes, the block raises `done` for one cycle. At that point the new carry, the negative and zero flags, and the instruction's cycle cost are valid on the outputs.

The control is one state machine with these states:

- **S_IDLE**: waits for `start`. When `start` arrives, the decoded instruction, the accumulator and the incoming carry are latched. The machine then goes to S_READ, or to S_PAD if the opcode is not recognised.
- **S_READ**: drives the byte address with the read strobe and always moves to S_CAPT.
- **S_CAPT**: takes the returned byte and registers the new carry, flags and write byte. It then goes to S_WRITE for read-modify-write instructions. Otherwise it goes to S_PAD, or straight to S_DONE when the cycle budget is already used up.
- **S_WRITE**: drives the write strobe for one cycle, then goes to S_PAD or S_DONE.
- **S_PAD**: idles until the cycle budget of the instruction is reached, then goes to S_DONE.
- **S_DONE**: asserts `done` and returns to S_IDLE.

The carry flag is given to the block at `start` as `carry_in` and is returned on `carry_out`.

Top module: `bitproc_unit`

## Requirements
- R1: For memory-bit instructions, the byte address is {`oper_hi`[3:0], `oper_lo`}, the bit index is `oper_hi`[7:5], and `oper_hi`[4]=1 selects the inverted memory bit (M' = NOT M; otherwise M' = M).
- R2: Opcode 8Bh sets the carry to C AND M' and takes 4 cycles.
- R3: Opcode 6Bh sets the carry to C OR M'. Opcode ABh sets it to C XOR M'. Both take 5 cycles.
- R4: Opcode CBh loads the carry with M' and takes 4 cycles.
- R5: Opcode EBh writes the carry into the addressed bit and takes 5 cycles. Every read-modify-write instruction except the masked pair of R8 changes only the addressed bit.
- R6: Opcode 4Bh inverts the addressed bit, ignores `oper_hi`[4], and takes 5 cycles.
- R7: An opcode whose low nibble is 1h sets (opcode bit 4 = 0) or clears (opcode bit 4 = 1) bit opcode[7:5] of the byte at {`page_sel`, `oper_lo`}. It takes 4 cycles.
- R8: Opcode 3Ch writes M OR A and opcode 5Ch writes M AND NOT A, with the address as in R1. Both set `neg_flag` to bit 7 of (A − M) mod 256 and `zero_flag` to whether that difference is zero. Both take 6 cycles.
- R9: Each memory instruction reads once, in cycle 1. Only the instructions of R5–R8 write, exactly once, in cycle 3. The read-only instructions of R2–R4 never assert `mem_wr`.
- R10: Cycle 1 is the cycle after the edge that accepts `start`. `done` is high for exactly one cycle, in the cycle equal to the instruction's cost, and `op_cycles` then reports that cost.
- R11: A `start` that arrives while `busy` is high is ignored: it starts no second instruction and causes no memory access.
- R12: Any other opcode makes no memory access, keeps the carry, and finishes with `done` in cycle 2.
- R13: After reset `busy`, `done`, `mem_rd`, `mem_wr`, `carry_out`, `neg_flag` and `zero_flag` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an instruction (accepted only when idle) |
| opcode | input | 8 | Instruction opcode byte |
| oper_lo | input | 8 | First operand byte |
| oper_hi | input | 8 | Second operand byte (address high, complement, bit index) |
| page_sel | input | 1 | Direct-page select for set/clear |
| acc | input | 8 | Accumulator, used as the mask for the masked pair |
| carry_in | input | 1 | Carry flag value at start |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | One-cycle completion pulse |
| carry_out | output | 1 | Resulting carry flag |
| neg_flag | output | 1 | Negative flag from A − M |
| zero_flag | output | 1 | Zero flag from A − M |
| op_cycles | output | 4 | Cycle cost of the last instruction |
| mem_addr | output | 12 | Memory byte address |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, valid one cycle after `mem_rd` |

## Verification
The assertions check, on every cycle, the handshake properties:

- `done` lasts one cycle, and `busy` holds until `done`.
- Read and write strobes never overlap, and a write always comes two cycles after a read.
- Writes happen only for read-modify-write kinds, and single-bit writes flip at most one bit of the byte read.
- An unrecognised opcode never touches memory.

Only the bench scenarios can show the Boolean results themselves: the carry for each operator with and without complement, the exact written byte, the flags of the masked pair, the cycle cost of each instruction, and that a second `start` during an instruction leaves memory untouched.

// File: rtl/bitproc_pkg.sv
package bitproc_pkg;

    parameter int BP_ADDR_W = 12;
    parameter int BP_DATA_W = 8;
    parameter int BP_CYC_W  = 4;
    localparam int BP_BIT_W = $clog2(BP_DATA_W);

    typedef enum logic [3:0] {
        K_NONE, K_AND, K_OR, K_XOR, K_LDC, K_STC,
        K_NOT, K_SET, K_CLR, K_TSET, K_TCLR
    } op_kind_e;

    typedef enum logic [2:0] {
        S_IDLE, S_READ, S_CAPT, S_WRITE, S_PAD, S_DONE
    } state_e;

    typedef struct packed {
        op_kind_e                kind;
        logic                    comp;
        logic [BP_BIT_W-1:0]     bitpos;
        logic [BP_ADDR_W-1:0]    addr;
        logic [BP_CYC_W-1:0]     cycles;
        logic                    writes;
    } dec_t;

endpackage

// File: rtl/bitproc_decode.sv
module bitproc_decode
    import bitproc_pkg::*;
(
    input  logic [BP_DATA_W-1:0] opcode,
    input  logic [BP_DATA_W-1:0] oper_lo,
    input  logic [BP_DATA_W-1:0] oper_hi,
    input  logic                 page_sel,
    output dec_t                 dec
);
    localparam int PAD_W = BP_ADDR_W - BP_DATA_W - 1;

    logic [BP_ADDR_W-1:0] full_addr;
    logic [BP_ADDR_W-1:0] page_addr;

    assign full_addr = {oper_hi[BP_ADDR_W-BP_DATA_W-1:0], oper_lo};
    assign page_addr = {{PAD_W{1'b0}}, page_sel, oper_lo};

    always_comb begin
        dec        = '0;
        dec.kind   = K_NONE;
        dec.cycles = BP_CYC_W'(2);
        dec.addr   = full_addr;
        dec.bitpos = oper_hi[BP_DATA_W-1 -: BP_BIT_W];
        dec.comp   = oper_hi[4];
        case (opcode)
            8'h8B: begin dec.kind = K_AND;  dec.cycles = BP_CYC_W'(4); end
            8'h6B: begin dec.kind = K_OR;   dec.cycles = BP_CYC_W'(5); end
            8'hAB: begin dec.kind = K_XOR;  dec.cycles = BP_CYC_W'(5); end
            8'hCB: begin dec.kind = K_LDC;  dec.cycles = BP_CYC_W'(4); end
            8'hEB: begin dec.kind = K_STC;  dec.cycles = BP_CYC_W'(5); dec.writes = 1'b1; end
            8'h4B: begin dec.kind = K_NOT;  dec.cycles = BP_CYC_W'(5); dec.writes = 1'b1; end
            8'h3C: begin dec.kind = K_TSET; dec.cycles = BP_CYC_W'(6); dec.writes = 1'b1; end
            8'h5C: begin dec.kind = K_TCLR; dec.cycles = BP_CYC_W'(6); dec.writes = 1'b1; end
            default: begin
                if (opcode[3:0] == 4'h1) begin
                    dec.kind   = opcode[4] ? K_CLR : K_SET;
                    dec.cycles = BP_CYC_W'(4);
                    dec.writes = 1'b1;
                    dec.addr   = page_addr;
                    dec.bitpos = opcode[BP_DATA_W-1 -: BP_BIT_W];
                end
            end
        endcase
    end

endmodule

// File: rtl/bitproc_alu.sv
module bitproc_alu
    import bitproc_pkg::*;
(
    input  op_kind_e              kind,
    input  logic                  comp,
    input  logic [BP_BIT_W-1:0]   bitpos,
    input  logic                  carry,
    input  logic [BP_DATA_W-1:0]  acc,
    input  logic [BP_DATA_W-1:0]  rdata,
    output logic                  carry_nx,
    output logic [BP_DATA_W-1:0]  wbyte,
    output logic                  neg,
    output logic                  zero
);
    logic                 mbit;
    logic                 opnd;
    logic                 new_bit;
    logic [BP_DATA_W-1:0] bit_byte;
    logic [BP_DATA_W-1:0] diff;

    assign mbit = rdata[bitpos];
    assign opnd = mbit ^ comp;
    assign diff = acc - rdata;
    assign neg  = diff[BP_DATA_W-1];
    assign zero = (diff == '0);

    always_comb begin
        case (kind)
            K_AND:   carry_nx = carry & opnd;
            K_OR:    carry_nx = carry | opnd;
            K_XOR:   carry_nx = carry ^ opnd;
            K_LDC:   carry_nx = opnd;
            default: carry_nx = carry;
        endcase
    end

    always_comb begin
        case (kind)
            K_STC:   new_bit = carry;
            K_NOT:   new_bit = ~mbit;
            K_SET:   new_bit = 1'b1;
            default: new_bit = 1'b0;
        endcase
    end

    for (genvar i = 0; i < BP_DATA_W; i++) begin : g_bit
        assign bit_byte[i] = (bitpos == BP_BIT_W'(i)) ? new_bit : rdata[i];
    end

    always_comb begin
        case (kind)
            K_TSET:  wbyte = rdata | acc;
            K_TCLR:  wbyte = rdata & ~acc;
            default: wbyte = bit_byte;
        endcase
    end

endmodule

// File: rtl/bitproc_unit.sv
module bitproc_unit
    import bitproc_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic [BP_DATA_W-1:0]  opcode,
    input  logic [BP_DATA_W-1:0]  oper_lo,
    input  logic [BP_DATA_W-1:0]  oper_hi,
    input  logic                  page_sel,
    input  logic [BP_DATA_W-1:0]  acc,
    input  logic                  carry_in,
    output logic                  busy,
    output logic                  done,
    output logic                  carry_out,
    output logic                  neg_flag,
    output logic                  zero_flag,
    output logic [BP_CYC_W-1:0]   op_cycles,
    output logic [BP_ADDR_W-1:0]  mem_addr,
    output logic                  mem_rd,
    output logic                  mem_wr,
    output logic [BP_DATA_W-1:0]  mem_wdata,
    input  logic [BP_DATA_W-1:0]  mem_rdata
);
    state_e               state_q, state_d;
    dec_t                 dec, dec_q;
    op_kind_e             kind_cur;
    logic [BP_DATA_W-1:0] acc_q, wbyte_q, wbyte;
    logic [BP_CYC_W-1:0]  cyc_q, cyc_last, cycles_q;
    logic                 carry_q, carry_nx, neg_q, zero_q, neg_c, zero_c;
    logic                 budget_end;

    bitproc_decode u_dec (
        .opcode   (opcode),
        .oper_lo  (oper_lo),
        .oper_hi  (oper_hi),
        .page_sel (page_sel),
        .dec      (dec)
    );

    bitproc_alu u_alu (
        .kind     (dec_q.kind),
        .comp     (dec_q.comp),
        .bitpos   (dec_q.bitpos),
        .carry    (carry_q),
        .acc      (acc_q),
        .rdata    (mem_rdata),
        .carry_nx (carry_nx),
        .wbyte    (wbyte),
        .neg      (neg_c),
        .zero     (zero_c)
    );

    assign kind_cur   = dec_q.kind;
    assign cyc_last   = dec_q.cycles - BP_CYC_W'(1);
    assign budget_end = (cyc_q == cyc_last);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (start) state_d = (dec.kind == K_NONE) ? S_PAD : S_READ;
            S_READ:  state_d = S_CAPT;
            S_CAPT:  state_d = dec_q.writes ? S_WRITE : (budget_end ? S_DONE : S_PAD);
            S_WRITE: state_d = budget_end ? S_DONE : S_PAD;
            S_PAD:   state_d = budget_end ? S_DONE : S_PAD;
            S_DONE:  state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= S_IDLE;
            dec_q    <= '0;
            acc_q    <= '0;
            wbyte_q  <= '0;
            cyc_q    <= '0;
            cycles_q <= '0;
            carry_q  <= 1'b0;
            neg_q    <= 1'b0;
            zero_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == S_IDLE) begin
                if (start) begin
                    dec_q   <= dec;
                    acc_q   <= acc;
                    carry_q <= carry_in;
                    cyc_q   <= BP_CYC_W'(1);
                end
            end else begin
                cyc_q <= cyc_q + BP_CYC_W'(1);
            end
            if (state_q == S_CAPT) begin
                carry_q <= carry_nx;
                wbyte_q <= wbyte;
                if (dec_q.kind == K_TSET || dec_q.kind == K_TCLR) begin
                    neg_q  <= neg_c;
                    zero_q <= zero_c;
                end
            end
            if (state_d == S_DONE && state_q != S_DONE)
                cycles_q <= cyc_q + BP_CYC_W'(1);
        end
    end

    always_comb begin
        busy      = (state_q != S_IDLE);
        done      = (state_q == S_DONE);
        mem_rd    = (state_q == S_READ);
        mem_wr    = (state_q == S_WRITE);
        mem_addr  = dec_q.addr;
        mem_wdata = wbyte_q;
        carry_out = carry_q;
        neg_flag  = neg_q;
        zero_flag = zero_q;
        op_cycles = cycles_q;
    end

endmodule

// File: rtl/bitproc_chk.sv
module bitproc_chk
    import bitproc_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic                 busy,
    input logic                 done,
    input logic                 mem_rd,
    input logic                 mem_wr,
    input logic [BP_DATA_W-1:0] mem_wdata,
    input logic [BP_DATA_W-1:0] mem_rdata,
    input op_kind_e             kind
);
    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10
    done_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

    // R11
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);

    // R9
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    // R9
    write_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> $past(mem_rd, 2));

    // R9
    write_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> (kind == K_STC || kind == K_NOT || kind == K_SET ||
                    kind == K_CLR || kind == K_TSET || kind == K_TCLR));

    // R5
    single_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr && kind != K_TSET && kind != K_TCLR)
            |-> $onehot0(mem_wdata ^ $past(mem_rdata)));

    // R12
    none_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && kind == K_NONE) |-> (!mem_rd && !mem_wr));

endmodule

bind bitproc_unit bitproc_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .done      (done),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr),
    .mem_wdata (mem_wdata),
    .mem_rdata (mem_rdata),
    .kind      (kind_cur)
);

// File: tb/bitproc_unit_tb_top.sv
`timescale 1ns/1ps
module bitproc_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  opcode = '0, oper_lo = '0, oper_hi = '0, acc = '0;
    logic        page_sel = 1'b0, carry_in = 1'b0;
    logic        busy, done, carry_out, neg_flag, zero_flag;
    logic [3:0]  op_cycles;
    logic [11:0] mem_addr;
    logic        mem_rd, mem_wr;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata = '0;

    logic [7:0]  mem [0:4095];
    int          rd_cnt = 0, wr_cnt = 0;
    int          n_chk = 0, n_fail = 0;
    int          meas_cyc, rd_d, wr_d;
    logic        c_res, n_res, z_res;
    logic [3:0]  rep_cyc;

    always #5 clk = ~clk;

    bitproc_unit dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode),
        .oper_lo(oper_lo), .oper_hi(oper_hi), .page_sel(page_sel),
        .acc(acc), .carry_in(carry_in), .busy(busy), .done(done),
        .carry_out(carry_out), .neg_flag(neg_flag), .zero_flag(zero_flag),
        .op_cycles(op_cycles), .mem_addr(mem_addr), .mem_rd(mem_rd),
        .mem_wr(mem_wr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    always @(posedge clk) begin
        if (mem_rd) begin mem_rdata <= mem[mem_addr]; rd_cnt <= rd_cnt + 1; end
        if (mem_wr) begin mem[mem_addr] <= mem_wdata; wr_cnt <= wr_cnt + 1; end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic run_op(input [7:0] opc, input [7:0] lo, input [7:0] hi,
                          input pg, input [7:0] a, input cin);
        int rd0, wr0, n;
        @(negedge clk);
        opcode = opc; oper_lo = lo; oper_hi = hi; page_sel = pg;
        acc = a; carry_in = cin; start = 1'b1;
        rd0 = rd_cnt; wr0 = wr_cnt;
        @(negedge clk);
        start = 1'b0;
        n = 1;
        while (!done && n < 40) begin @(negedge clk); n++; end
        meas_cyc = n; c_res = carry_out; n_res = neg_flag; z_res = zero_flag;
        rep_cyc = op_cycles;
        rd_d = rd_cnt - rd0; wr_d = wr_cnt - wr0;
        @(negedge clk);
        chk(!done, "R10 done width", done, 0);
    endtask

    // read-only carry operation at a full 12-bit address
    task automatic bool_case(input [7:0] opc, input [11:0] addr, input [2:0] bp,
                             input bit comp, input [7:0] mval, input bit cin,
                             input int exp_cyc, input string req);
        bit m, expc;
        mem[addr] = mval;
        m = mval[bp] ^ comp;
        case (opc)
            8'h8B:   expc = cin & m;
            8'h6B:   expc = cin | m;
            8'hAB:   expc = cin ^ m;
            default: expc = m;
        endcase
        run_op(opc, addr[7:0], {bp, comp, addr[11:8]}, 1'b0, 8'h00, cin);
        chk(c_res == expc, req, c_res, expc);
        chk(meas_cyc == exp_cyc, {req, " cycles"}, meas_cyc, exp_cyc);
        chk(rep_cyc == exp_cyc, "R10 op_cycles", rep_cyc, exp_cyc);
        chk(wr_d == 0, "R9 no write", wr_d, 0);
        chk(rd_d == 1, "R9 one read", rd_d, 1);
        chk(mem[addr] == mval, "R9 mem unchanged", mem[addr], mval);
    endtask

    task automatic test_reset;
        chk(!busy && !done, "R13 busy/done", {busy, done}, 0);
        chk(!mem_rd && !mem_wr, "R13 strobes", {mem_rd, mem_wr}, 0);
        chk(!carry_out && !neg_flag && !zero_flag, "R13 flags",
            {carry_out, neg_flag, zero_flag}, 0);
    endtask

    task automatic test_and_ldc;
        bool_case(8'h8B, 12'hA35, 3'd2, 1'b0, 8'h04, 1'b1, 4, "R2 and");
        bool_case(8'h8B, 12'hA35, 3'd2, 1'b1, 8'h04, 1'b1, 4, "R2 and-not R1");
        bool_case(8'h8B, 12'h123, 3'd7, 1'b0, 8'h80, 1'b0, 4, "R2 and c0");
        bool_case(8'hCB, 12'hFFF, 3'd0, 1'b0, 8'h01, 1'b0, 4, "R4 ldc");
        bool_case(8'hCB, 12'hFFF, 3'd0, 1'b1, 8'h01, 1'b1, 4, "R4 ldc-not");
    endtask

    task automatic test_or_xor;
        bool_case(8'h6B, 12'h040, 3'd5, 1'b0, 8'hDF, 1'b0, 5, "R3 or");
        bool_case(8'h6B, 12'h040, 3'd5, 1'b1, 8'hDF, 1'b0, 5, "R3 or-not");
        bool_case(8'hAB, 12'h7C1, 3'd3, 1'b0, 8'h08, 1'b1, 5, "R3 xor");
        bool_case(8'hAB, 12'h7C1, 3'd3, 1'b1, 8'h08, 1'b1, 5, "R3 xor-not");
    endtask

    task automatic rmw_check(input [11:0] addr, input [7:0] expb, input int exp_cyc,
                             input string req);
        chk(mem[addr] == expb, req, mem[addr], expb);
        chk(meas_cyc == exp_cyc, {req, " cycles"}, meas_cyc, exp_cyc);
        chk(wr_d == 1, "R9 one write", wr_d, 1);
    endtask

    task automatic test_stc_not;
        mem[12'hFFF] = 8'h00;
        run_op(8'hEB, 8'hFF, {3'd7, 1'b0, 4'hF}, 1'b0, 8'h00, 1'b1);
        rmw_check(12'hFFF, 8'h80, 5, "R5 stc c1");
        mem[12'h201] = 8'hFF;
        run_op(8'hEB, 8'h01, {3'd0, 1'b1, 4'h2}, 1'b0, 8'h00, 1'b0);
        rmw_check(12'h201, 8'hFE, 5, "R5 stc c0");
        chk(c_res == 1'b0, "R5 carry kept", c_res, 0);
        mem[12'h355] = 8'h5A;
        run_op(8'h4B, 8'h55, {3'd1, 1'b1, 4'h3}, 1'b0, 8'h00, 1'b1);
        rmw_check(12'h355, 8'h58, 5, "R6 not bit1");
        run_op(8'h4B, 8'h55, {3'd0, 1'b0, 4'h3}, 1'b0, 8'h00, 1'b1);
        rmw_check(12'h355, 8'h59, 5, "R6 not bit0");
    endtask

    task automatic test_set_clr;
        mem[12'h135] = 8'h00; mem[12'h035] = 8'h00;
        run_op({3'd6, 1'b0, 4'h1}, 8'h35, 8'h00, 1'b1, 8'h00, 1'b0);
        rmw_check(12'h135, 8'h40, 4, "R7 set page1");
        chk(mem[12'h035] == 8'h00, "R7 page0 untouched", mem[12'h035], 0);
        mem[12'h035] = 8'hFF;
        run_op({3'd2, 1'b1, 4'h1}, 8'h35, 8'h00, 1'b0, 8'h00, 1'b0);
        rmw_check(12'h035, 8'hFB, 4, "R7 clr page0");
        chk(mem[12'h135] == 8'h40, "R7 page1 untouched", mem[12'h135], 8'h40);
    endtask

    task automatic tst_case(input [7:0] opc, input [11:0] addr, input [7:0] m,
                            input [7:0] a, input string req);
        logic [7:0] diff, expb;
        mem[addr] = m;
        diff = a - m;
        expb = (opc == 8'h3C) ? (m | a) : (m & ~a);
        run_op(opc, addr[7:0], {4'h0, addr[11:8]}, 1'b0, a, 1'b1);
        rmw_check(addr, expb, 6, req);
        chk(n_res == diff[7], {req, " N"}, n_res, diff[7]);
        chk(z_res == (diff == 0), {req, " Z"}, z_res, diff == 0);
        chk(c_res == 1'b1, "R8 carry kept", c_res, 1);
    endtask

    task automatic test_masked;
        tst_case(8'h3C, 12'h030, 8'h0F, 8'h20, "R8 tset");
        tst_case(8'h5C, 12'h035, 8'hFF, 8'h20, "R8 tclr");
        tst_case(8'h3C, 12'h9AB, 8'h33, 8'h33, "R8 tset equal");
        tst_case(8'h5C, 12'h9AC, 8'h90, 8'h10, "R8 tclr below");
    endtask

    task automatic test_unknown;
        run_op(8'h00, 8'h12, 8'h34, 1'b0, 8'h00, 1'b1);
        chk(meas_cyc == 2, "R12 cycles", meas_cyc, 2);
        chk(rd_d == 0 && wr_d == 0, "R12 no access", rd_d + wr_d, 0);
        chk(c_res == 1'b1, "R12 carry kept", c_res, 1);
    endtask

    task automatic test_busy_start;
        int wr0, rd0, n;
        mem[12'h444] = 8'h00; mem[12'h155] = 8'h00;
        wr0 = wr_cnt; rd0 = rd_cnt;
        @(negedge clk);
        opcode = 8'h4B; oper_lo = 8'h44; oper_hi = {3'd4, 1'b0, 4'h4};
        carry_in = 1'b0; start = 1'b1;
        @(negedge clk);
        opcode = {3'd0, 1'b0, 4'h1}; oper_lo = 8'h55; page_sel = 1'b1;
        @(negedge clk);
        start = 1'b0;
        n = 2;
        while (!done && n < 40) begin @(negedge clk); n++; end
        chk(n == 5, "R11 first op cost", n, 5);
        repeat (4) @(negedge clk);
        chk(!busy, "R11 no second op", busy, 0);
        chk(wr_cnt - wr0 == 1 && rd_cnt - rd0 == 1, "R11 one access pair",
            wr_cnt - wr0, 1);
        chk(mem[12'h444] == 8'h10, "R11 first op result", mem[12'h444], 8'h10);
        chk(mem[12'h155] == 8'h00, "R11 ignored target", mem[12'h155], 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 4096; i++) mem[i] = 8'h00;
        repeat (3) @(negedge clk);
        test_reset();
        rst_n = 1'b1;
        @(negedge clk);
        test_and_ldc();
        test_or_xor();
        test_stc_not();
        test_set_clr();
        test_masked();
        test_unknown();
        test_busy_start();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule